// File: doc/BRIEF.md
# Block Address Translation Array

This unit translates effective addresses to physical addresses through a small set of large, software-loaded mappings. It holds two banks of block mappings: one consulted by instruction fetches and one consulted by data accesses. Each bank has `ENTRIES` slots, four by default. Each slot is a pair of 32-bit words, a match word and a target word. Software fills a slot one word at a time through a write port, using a bank, a slot number and a word selector.

For every request the unit is given an effective address and three flags: fetch or data, supervisor or user, and load or store. It searches the selected bank and reports the result one clock later. The result is a hit, a fault, the physical address (36 bits) and four cache attribute bits. A matching slot hands over the low effective-index bits chosen by its length mask, plus the whole 17-bit byte offset, to the physical address. Slots are valid separately for supervisor and user accesses. When several slots match, the lowest-numbered one wins.

The datapath has no sequencing, so it has no state machine. It is a pure comparison and select stage followed by one result register.

Top module: `bat_xlate`

## Requirements
- R1: After reset every slot in both banks is invalid, so every request reports hit=0 and fault=0.
- R2: A write with `cfg_we` loads `cfg_data` into the slot chosen by `cfg_bank` (1 = fetch bank) and `cfg_slot`. `cfg_hi`=1 selects the match word and 0 selects the target word. Requests from the next cycle on see the new value.
- R3: A slot matches when effective address bits 31:17 equal match-word bits 31:17, with bits ignored where the length mask is set. The length mask is match-word bits 12:2, and mask bit k covers address bit 17+k. So 0x000 gives a 128 KB block, 0x01C gives 1 MB and 0x1FFC gives 256 MB, in general 2^(17+ones) bytes.
- R4: A slot may match supervisor requests only if match-word bit 1 is set. It may match user requests only if match-word bit 0 is set.
- R5: On a hit, physical bits 31:17 are target-word bits 31:17, with each masked position taken from the effective address instead. Physical bits 16:0 equal effective bits 16:0.
- R6: On a hit, physical bits 35:33 are target-word bits 11:9 and physical bit 32 is target-word bit 2.
- R7: On a hit, `rsp_attr` = {write-through, inhibit, coherent, guarded} = target-word bits {6,5,4,3}.
- R8: The guarded bit of a fetch-bank slot is always stored as 0, so fetch hits report `rsp_attr[0]`=0.
- R9: The access rights field is target-word bits 1:0. A value of 10 allows load and store. A value of 01 or 11 allows load only. A value of 00 allows nothing. A refused access reports fault=1, hit=0, and a zero address and attributes.
- R10: Among matching slots the lowest slot number alone decides the result, including its access rights.
- R11: A fetch request searches only the fetch bank and a data request searches only the data bank.
- R12: `rsp_valid` and the other results appear on the clock edge after the request edge. Without a request, valid, hit and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Slot word write strobe |
| cfg_bank | input | 1 | 1 = fetch bank, 0 = data bank |
| cfg_slot | input | SLOT_W | Slot number |
| cfg_hi | input | 1 | 1 = match word, 0 = target word |
| cfg_data | input | 32 | Word to store |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Matching slot refused the access |
| rsp_pa | output | 36 | Physical address |
| rsp_attr | output | 4 | {W, I, M, G} attributes |

## Verification
A 128 KB slot is probed at an offset inside its block and one block past it. A 1 MB slot is probed at its top byte, at an offset whose target bits fall in the masked field, and just past its end. Together these separate correct mask handling from plain compares and from copying target bits that the mask should override.

Supervisor-only and user-only versions of one slot show whether each valid bit is tied to its own privilege. Two overlapping fetch slots with different rights and targets show which slot wins. Removing the lower slot afterwards shows that the next slot takes over.

All four rights codes are tried with loads and stores. Identical addresses are also sent to the other bank, and the guarded bit is written into both banks.

// File: rtl/bat_pkg.sv
package bat_pkg;
    localparam int WORD_W  = 32;
    localparam int OFS_W   = 17;
    localparam int BLK_W   = WORD_W - OFS_W;
    localparam int LEN_W   = 11;
    localparam int XHI_W   = 3;
    localparam int PA_W    = WORD_W + XHI_W + 1;
    localparam int ATTR_W  = 4;
    localparam int PROT_W  = 2;

    localparam logic [PROT_W-1:0] PROT_NONE = 2'b00;
    localparam logic [PROT_W-1:0] PROT_RW   = 2'b10;

    typedef struct packed {
        logic [BLK_W-1:0]  epi;
        logic [LEN_W-1:0]  len;
        logic              sv;
        logic              uv;
        logic [BLK_W-1:0]  rpi;
        logic [XHI_W-1:0]  xhi;
        logic              x32;
        logic [ATTR_W-1:0] attr;
        logic [PROT_W-1:0] prot;
    } bat_slot_t;
endpackage

// File: rtl/bat_store.sv
module bat_store
    import bat_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_bank,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_hi,
    input  logic [WORD_W-1:0] cfg_data,
    output bat_slot_t         slots_o [2*ENTRIES]
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_data[16:13], cfg_data[8:7]};

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
            bat_slot_t q;
            logic      sel;
            assign sel = cfg_we && (cfg_bank == b[0]) && (cfg_slot == e[SLOT_W-1:0]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (sel) begin
                    if (cfg_hi) begin
                        q.epi <= cfg_data[WORD_W-1:OFS_W];
                        q.len <= cfg_data[LEN_W+1:2];
                        q.sv  <= cfg_data[1];
                        q.uv  <= cfg_data[0];
                    end else begin
                        q.rpi  <= cfg_data[WORD_W-1:OFS_W];
                        q.xhi  <= cfg_data[11:9];
                        q.x32  <= cfg_data[2];
                        q.attr <= {cfg_data[6:4], (b == 1) ? 1'b0 : cfg_data[3]};
                        q.prot <= cfg_data[1:0];
                    end
                end
            end
            assign slots_o[b*ENTRIES+e] = q;
        end
    end
endmodule

// File: rtl/bat_match.sv
module bat_match
    import bat_pkg::*;
(
    input  bat_slot_t         slot,
    input  logic [WORD_W-1:0] ea,
    input  logic              super_i,
    output logic              hit,
    output logic [PA_W-1:0]   pa
);
    logic [BLK_W-1:0] mask;
    logic [BLK_W-1:0] blk;
    logic             priv_ok;

    always_comb begin
        mask    = {{(BLK_W-LEN_W){1'b0}}, slot.len};
        priv_ok = super_i ? slot.sv : slot.uv;
        hit     = priv_ok && (((ea[WORD_W-1:OFS_W] ^ slot.epi) & ~mask) == '0);
        blk     = (slot.rpi & ~mask) | (ea[WORD_W-1:OFS_W] & mask);
        pa      = {slot.xhi, slot.x32, blk, ea[OFS_W-1:0]};
    end
endmodule

// File: rtl/bat_pick.sv
module bat_pick
    import bat_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0] hits,
    input  logic [PA_W-1:0]    pa_in   [ENTRIES],
    input  bat_slot_t          slot_in [ENTRIES],
    output logic               any,
    output logic [PA_W-1:0]    pa_out,
    output logic [ATTR_W-1:0]  attr_out,
    output logic [PROT_W-1:0]  prot_out
);
    always_comb begin
        any      = 1'b0;
        pa_out   = '0;
        attr_out = '0;
        prot_out = PROT_NONE;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any      = 1'b1;
                pa_out   = pa_in[i];
                attr_out = slot_in[i].attr;
                prot_out = slot_in[i].prot;
            end
        end
    end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_bank,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_hi,
    input  logic [31:0]       cfg_data,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic              req_fetch,
    input  logic              req_super,
    input  logic              req_store,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [35:0]       rsp_pa,
    output logic [3:0]        rsp_attr
);
    bat_slot_t           all_slots [2*ENTRIES];
    bat_slot_t           bank      [ENTRIES];
    logic [PA_W-1:0]     cand_pa   [ENTRIES];
    logic [ENTRIES-1:0]  cand_hit;
    logic                any_hit;
    logic [PA_W-1:0]     win_pa;
    logic [ATTR_W-1:0]   win_attr;
    logic [PROT_W-1:0]   win_prot;
    logic                deny;
    logic                grant;

    bat_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_bank (cfg_bank),
        .cfg_slot (cfg_slot),
        .cfg_hi   (cfg_hi),
        .cfg_data (cfg_data),
        .slots_o  (all_slots)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign bank[e] = req_fetch ? all_slots[ENTRIES+e] : all_slots[e];
        bat_match u_match (
            .slot    (bank[e]),
            .ea      (req_ea),
            .super_i (req_super),
            .hit     (cand_hit[e]),
            .pa      (cand_pa[e])
        );
    end

    bat_pick #(.ENTRIES(ENTRIES)) u_pick (
        .hits     (cand_hit),
        .pa_in    (cand_pa),
        .slot_in  (bank),
        .any      (any_hit),
        .pa_out   (win_pa),
        .attr_out (win_attr),
        .prot_out (win_prot)
    );

    always_comb begin
        deny  = any_hit && ((win_prot == PROT_NONE) ||
                            (req_store && (win_prot != PROT_RW)));
        grant = any_hit && !deny;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
            rsp_attr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && grant;
            rsp_fault <= req_valid && deny;
            rsp_pa    <= (req_valid && grant) ? win_pa   : '0;
            rsp_attr  <= (req_valid && grant) ? win_attr : '0;
        end
    end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_ea,
    input logic        req_fetch,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_fault,
    input logic [35:0] rsp_pa,
    input logic [3:0]  rsp_attr
);
    assert_hit_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || (rsp_pa[16:0] == $past(req_ea[16:0]))));

    assert_fetch_unguarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> !rsp_attr[0]);

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));
endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ea    (req_ea),
    .req_fetch (req_fetch),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa),
    .rsp_attr  (rsp_attr)
);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_bank = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic        cfg_hi = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_fetch = 1'b0;
    logic        req_super = 1'b0;
    logic        req_store = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [35:0] rsp_pa;
    logic [3:0]  rsp_attr;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    bat_xlate #(.ENTRIES(4)) uut (.*);

    task automatic put(input logic bank, input logic [1:0] slot, input logic hi,
                       input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = bank; cfg_slot = slot; cfg_hi = hi; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input string req, input logic fetch, input logic sup,
                        input logic st, input logic [31:0] ea,
                        input logic ehit, input logic efault,
                        input logic [35:0] epa, input logic [3:0] eattr);
        logic [41:0] act, exp;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_fetch = fetch; req_super = sup; req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
        act = {rsp_valid, rsp_hit, rsp_fault, rsp_pa, rsp_attr[2:0]};
        exp = {1'b1, ehit, efault, epa, eattr[2:0]};
        n_checks++;
        if (act != exp || rsp_attr[3] != eattr[3]) begin
            n_fails++;
            $display("FAIL %s ea=%h: got v/h/f/pa/attr=%b/%b/%b/%h/%b expected %b/%b/%b/%h/%b",
                     req, ea, rsp_valid, rsp_hit, rsp_fault, rsp_pa, rsp_attr,
                     1'b1, ehit, efault, epa, eattr);
        end
    endtask

    task automatic t_reset;
        look("R1", 1'b0, 1'b1, 1'b0, 32'h1000_0000, 0, 0, 36'h0, 4'h0);
        look("R1", 1'b1, 1'b0, 1'b0, 32'h0000_0000, 0, 0, 36'h0, 4'h0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        n_checks++;
        if (rsp_valid || rsp_hit || rsp_fault) begin
            n_fails++;
            $display("FAIL R12 idle: got v/h/f=%b/%b/%b expected 0/0/0",
                     rsp_valid, rsp_hit, rsp_fault);
        end
    endtask

    task automatic t_basic;
        put(0, 0, 1, 32'h1000_0003);
        put(0, 0, 0, 32'h8000_0062);
        look("R2 R3 R7", 0, 1, 0, 32'h1001_2345, 1, 0, 36'h0_8001_2345, 4'b1100);
        look("R3 past block", 0, 1, 0, 32'h1002_0000, 0, 0, 36'h0, 4'h0);
    endtask

    task automatic t_mask;
        put(0, 1, 1, 32'h2000_001F);
        put(0, 1, 0, 32'h4006_0002);
        look("R3 R5 top", 0, 0, 0, 32'h200F_FFFC, 1, 0, 36'h0_400F_FFFC, 4'h0);
        look("R5 masked", 0, 0, 1, 32'h2000_0010, 1, 0, 36'h0_4000_0010, 4'h0);
        look("R3 past 1M", 0, 0, 0, 32'h2010_0000, 0, 0, 36'h0, 4'h0);
    endtask

    task automatic t_priv;
        put(0, 2, 1, 32'h3000_0002);
        put(0, 2, 0, 32'h3300_0002);
        look("R4 sup", 0, 1, 0, 32'h3000_0004, 1, 0, 36'h0_3300_0004, 4'h0);
        look("R4 user", 0, 0, 0, 32'h3000_0004, 0, 0, 36'h0, 4'h0);
        put(0, 2, 1, 32'h3000_0001);
        look("R4 user ok", 0, 0, 0, 32'h3000_0004, 1, 0, 36'h0_3300_0004, 4'h0);
        look("R4 sup no", 0, 1, 0, 32'h3000_0004, 0, 0, 36'h0, 4'h0);
    endtask

    task automatic t_ext;
        put(0, 3, 1, 32'h5000_0003);
        put(0, 3, 0, 32'h6000_0A06);
        look("R6", 0, 1, 0, 32'h5000_0ABC, 1, 0, 36'hB_6000_0ABC, 4'h0);
    endtask

    task automatic t_prot;
        look("R9 rw store", 0, 1, 1, 32'h1000_0040, 1, 0, 36'h0_8000_0040, 4'b1100);
        put(0, 0, 0, 32'h8000_0061);
        look("R9 ro load", 0, 1, 0, 32'h1000_0040, 1, 0, 36'h0_8000_0040, 4'b1100);
        look("R9 ro store", 0, 1, 1, 32'h1000_0040, 0, 1, 36'h0, 4'h0);
        put(0, 0, 0, 32'h8000_0063);
        look("R9 11 load", 0, 1, 0, 32'h1000_0040, 1, 0, 36'h0_8000_0040, 4'b1100);
        look("R9 11 store", 0, 1, 1, 32'h1000_0040, 0, 1, 36'h0, 4'h0);
        put(0, 0, 0, 32'h8000_0060);
        look("R9 none load", 0, 1, 0, 32'h1000_0040, 0, 1, 36'h0, 4'h0);
        put(0, 0, 0, 32'h8000_0062);
    endtask

    task automatic t_prio;
        put(1, 1, 1, 32'h7000_0003);
        put(1, 1, 0, 32'h1100_0001);
        put(1, 2, 1, 32'h7000_001F);
        put(1, 2, 0, 32'h2200_0002);
        look("R10 low wins", 1, 1, 0, 32'h7000_1234, 1, 0, 36'h0_1100_1234, 4'h0);
        look("R10 low rights", 1, 1, 1, 32'h7000_1234, 0, 1, 36'h0, 4'h0);
        put(1, 1, 1, 32'h0000_0000);
        look("R10 next slot", 1, 1, 1, 32'h7000_1234, 1, 0, 36'h0_2200_1234, 4'h0);
    endtask

    task automatic t_side;
        look("R11 data bank", 0, 1, 0, 32'h7000_1234, 0, 0, 36'h0, 4'h0);
        look("R11 fetch bank", 1, 1, 0, 32'h1001_2345, 0, 0, 36'h0, 4'h0);
    endtask

    task automatic t_guard;
        put(1, 0, 1, 32'h0800_0003);
        put(1, 0, 0, 32'h0900_001A);
        look("R8 fetch", 1, 1, 0, 32'h0800_0010, 1, 0, 36'h0_0900_0010, 4'b0010);
        put(0, 2, 1, 32'h0800_0003);
        put(0, 2, 0, 32'h0A00_000A);
        look("R7 data G", 0, 1, 0, 32'h0800_0010, 1, 0, 36'h0_0A00_0010, 4'b0001);
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL R12 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_basic();
        t_mask();
        t_priv();
        t_ext();
        t_prot();
        t_prio();
        t_side();
        t_guard();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule